// File: doc/BRIEF.md
# Status Register and Block Write Protection Unit

This unit keeps the status byte of a small serial memory and decides, cycle by cycle, whether a write may go ahead. It holds a two-bit protection code, a write-enable latch and shows a busy flag. A command decoder sends it single-cycle pulses for the set-enable, clear-enable and status-write commands, with the data byte for the last one. It also gets the active-low write-protect pin, the busy flag from the program timer and the array address of the write under test.

It returns the byte that a status read shifts out. It also drives two permission signals, one for an array write at the given address and one for a status write. The program timer uses these permissions to start a self-timed cycle. When that cycle ends, the unit clears the write-enable latch by itself. The protection code stands in for nonvolatile bits. It survives the warm reset and is cleared only by the power-on reset.

Top module: `srprot_unit`

## Requirements
- R1: After the power-on reset the status byte reads 0x00 and both permission outputs are low.
- R2: A set-enable pulse sets the write-enable latch, shown in status bit 1. A clear-enable pulse clears it. When both pulses come in the same cycle, the latch ends up cleared.
- R3: The status byte has bits 7..4 at 0, bit 3 as protection bit 1, bit 2 as protection bit 0, bit 1 as the write-enable latch and bit 0 at 0. While busy is high, the byte reads exactly 0x01.
- R4: A status-write pulse is accepted only when write-protect is high, the latch is 1 and busy is low. An accepted pulse copies data bits 3 and 2 into protection bits 1 and 0 and ignores the other data bits. A refused pulse changes nothing.
- R5: For a 9-bit address, protection code 00 protects nothing, 01 protects 0x180..0x1FF, 10 protects 0x100..0x1FF and 11 protects every address. Array permission is low for any protected address.
- R6: Write-protect low, or the latch at 0, forces both permission outputs low.
- R7: The latch clears in the cycle after busy falls. If a set-enable pulse comes in that same cycle, the latch ends up set.
- R8: Set-enable, clear-enable and status-write pulses that arrive while busy is high have no effect. Both permissions stay low while busy.
- R9: The warm reset clears the latch and keeps the protection code. The power-on reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstN | input | 1 | Warm reset, active low, asynchronous |
| cmdWren | input | 1 | Set-enable command pulse |
| cmdWrdi | input | 1 | Clear-enable command pulse |
| cmdWrsr | input | 1 | Status-write command pulse |
| wrData | input | 8 | Data byte of the status write |
| wpN | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Program cycle in progress |
| addr | input | ADDR_W | Array address under test |
| statusByte | output | 8 | Byte returned by a status read |
| arrayWriteOk | output | 1 | Array write at addr permitted |
| statusWriteOk | output | 1 | Status write permitted |

## Verification
Two events can land in the same cycle: the end of a program cycle, which clears the latch, and a set-enable pulse, which sets it. The bench lowers busy and pulses set-enable on the same edge, then reads status bit 1 and expects it to be 1. It also checks the plain end of a cycle, where it expects 0. Set-enable and clear-enable are also given together, and the expected result is a cleared latch.

// File: rtl/srprot_pkg.sv
package srprot_pkg;
  typedef struct packed {
    logic setWen;
    logic clrWen;
    logic loadBp;
  } srStrobes_t;

  localparam logic [1:0] BP_NONE    = 2'b00;
  localparam logic [1:0] BP_QUARTER = 2'b01;
  localparam logic [1:0] BP_HALF    = 2'b10;
  localparam logic [1:0] BP_ALL     = 2'b11;
endpackage

// File: rtl/srprot_ctrl.sv
module srprot_ctrl
  import srprot_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       cmdWren,
  input  logic       cmdWrdi,
  input  logic       cmdWrsr,
  input  logic       wpN,
  input  logic       busy,
  input  logic       wenQ,
  output srStrobes_t strobes,
  output logic       statusWriteOk
);
  logic anyRstN;
  logic busyQ;
  logic cycleDone;
  logic idle;

  assign anyRstN = porN & rstN;

  // remembers last busy level to find the end of a program cycle
  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) busyQ <= 1'b0;
    else          busyQ <= busy;
  end

  assign cycleDone     = busyQ & ~busy;
  assign idle          = ~busy;
  assign statusWriteOk = wpN & wenQ & idle;

  always_comb begin
    strobes        = '0;
    // clear-enable beats set-enable; set-enable beats end-of-cycle clear
    strobes.clrWen = idle & (cmdWrdi | (cycleDone & ~cmdWren));
    strobes.setWen = idle & cmdWren & ~cmdWrdi;
    strobes.loadBp = cmdWrsr & statusWriteOk;
  end
endmodule

// File: rtl/srprot_dpath.sv
module srprot_dpath
  import srprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  srStrobes_t        strobes,
  input  logic [1:0]        bpIn,
  input  logic              busy,
  input  logic              statusWriteOk,
  input  logic [ADDR_W-1:0] addr,
  output logic              wenQ,
  output logic              arrayWriteOk,
  output logic [7:0]        statusByte
);
  localparam int TOP = ADDR_W - 1;

  logic       anyRstN;
  logic [1:0] bpQ;
  logic       inQuarter;
  logic       inHalf;
  logic       protHit;

  assign anyRstN = porN & rstN;

  // protection code: only the power-on reset clears it
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              bpQ <= BP_NONE;
    else if (strobes.loadBp) bpQ <= bpIn;
  end

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN)            wenQ <= 1'b0;
    else if (strobes.clrWen) wenQ <= 1'b0;
    else if (strobes.setWen) wenQ <= 1'b1;
  end

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign inQuarter = &addr[TOP:TOP-1];
    end else begin : g_narrow
      assign inQuarter = addr[TOP];
    end
  endgenerate
  assign inHalf = addr[TOP];

  always_comb begin
    unique case (bpQ)
      BP_NONE:    protHit = 1'b0;
      BP_QUARTER: protHit = inQuarter;
      BP_HALF:    protHit = inHalf;
      default:    protHit = 1'b1;
    endcase
  end

  assign arrayWriteOk = statusWriteOk & ~protHit;
  assign statusByte   = busy ? 8'h01 : {4'h0, bpQ, wenQ, 1'b0};
endmodule

// File: rtl/srprot_unit.sv
module srprot_unit
  import srprot_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic [7:0]        wrData,
  input  logic              wpN,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        statusByte,
  output logic              arrayWriteOk,
  output logic              statusWriteOk
);
  srStrobes_t strobes;
  logic       wenQ;
  logic       unusedWrBits;

  assign unusedWrBits = ^{wrData[7:4], wrData[1:0]};

  srprot_ctrl u_ctrl (
    .clk(clk), .porN(porN), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .wpN(wpN), .busy(busy), .wenQ(wenQ),
    .strobes(strobes), .statusWriteOk(statusWriteOk)
  );

  srprot_dpath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .porN(porN), .rstN(rstN),
    .strobes(strobes), .bpIn(wrData[3:2]), .busy(busy),
    .statusWriteOk(statusWriteOk), .addr(addr),
    .wenQ(wenQ), .arrayWriteOk(arrayWriteOk), .statusByte(statusByte)
  );
endmodule

// File: rtl/srprot_chk.sv
module srprot_chk (
  input logic       clk,
  input logic       porN,
  input logic       rstN,
  input logic       cmdWren,
  input logic       cmdWrdi,
  input logic       wpN,
  input logic       busy,
  input logic [7:0] statusByte,
  input logic       arrayWriteOk,
  input logic       statusWriteOk
);
  logic anyRstN;
  logic prevBusy;

  assign anyRstN = porN & rstN;

  always_ff @(posedge clk or negedge anyRstN) begin
    if (!anyRstN) prevBusy <= 1'b0;
    else          prevBusy <= busy;
  end

  assert_high_nibble_zero_R3: assert property (@(posedge clk) disable iff (!anyRstN)
    statusByte[7:4] == 4'h0);

  assert_busy_byte_R3: assert property (@(posedge clk) disable iff (!anyRstN)
    busy |-> statusByte == 8'h01);

  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!anyRstN)
    !wpN |-> (!arrayWriteOk && !statusWriteOk));

  assert_array_implies_status_R5: assert property (@(posedge clk) disable iff (!anyRstN)
    arrayWriteOk |-> statusWriteOk);

  assert_full_protect_R5: assert property (@(posedge clk) disable iff (!anyRstN)
    (!busy && statusByte[3:2] == 2'b11) |-> !arrayWriteOk);

  assert_busy_no_perm_R8: assert property (@(posedge clk) disable iff (!anyRstN)
    busy |-> (!arrayWriteOk && !statusWriteOk));

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!anyRstN)
    (cmdWrdi && !busy) |=> (busy || !statusByte[1]));

  assert_cycle_end_clears_R7: assert property (@(posedge clk) disable iff (!anyRstN)
    (prevBusy && !busy && !cmdWren) |=> (busy || !statusByte[1]));
endmodule

bind srprot_unit srprot_chk u_chk (
  .clk(clk), .porN(porN), .rstN(rstN),
  .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .wpN(wpN), .busy(busy),
  .statusByte(statusByte), .arrayWriteOk(arrayWriteOk),
  .statusWriteOk(statusWriteOk)
);

// File: tb/sim_srprot_unit.sv
module sim_srprot_unit;
  localparam int AW = 9;

  typedef struct packed {
    logic [7:0] st;
    logic       arr;
    logic       sto;
  } expect_t;

  logic          clk = 1'b0;
  logic          porN = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdWren = 1'b0, cmdWrdi = 1'b0, cmdWrsr = 1'b0;
  logic [7:0]    wrData = 8'h00;
  logic          wpN = 1'b1;
  logic          busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    statusByte;
  logic          arrayWriteOk, statusWriteOk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  expect_t expQ[$];
  string   tagQ[$];

  // bench model of the architectural state
  logic [1:0] mBp = 2'b00;
  logic       mWen = 1'b0;
  logic       mPrevBusy = 1'b0;

  always #10 clk = ~clk;

  srprot_unit #(.ADDR_W(AW)) u0 (
    .clk(clk), .porN(porN), .rstN(rstN),
    .cmdWren(cmdWren), .cmdWrdi(cmdWrdi), .cmdWrsr(cmdWrsr),
    .wrData(wrData), .wpN(wpN), .busy(busy), .addr(addr),
    .statusByte(statusByte), .arrayWriteOk(arrayWriteOk),
    .statusWriteOk(statusWriteOk)
  );

  function automatic logic isProt(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  // driver: set inputs at falling edge, push expected post-edge outputs
  task automatic step(input logic wr, input logic wd, input logic ws,
                      input logic [7:0] d, input logic wp, input logic bz,
                      input logic [AW-1:0] a, input string tag);
    expect_t e;
    logic accept;
    logic fall;
    @(negedge clk);
    cmdWren = wr; cmdWrdi = wd; cmdWrsr = ws; wrData = d;
    wpN = wp; busy = bz; addr = a;
    fall   = mPrevBusy & ~bz;
    accept = ws & wp & mWen & ~bz;
    if (!bz) begin
      if (wd)        mWen = 1'b0;
      else if (wr)   mWen = 1'b1;
      else if (fall) mWen = 1'b0;
    end
    if (accept) mBp = d[3:2];
    mPrevBusy = bz;
    e.st  = bz ? 8'h01 : {4'h0, mBp, mWen, 1'b0};
    e.sto = wp & mWen & ~bz;
    e.arr = e.sto & ~isProt(mBp, a);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(posedge clk);
  endtask

  task automatic doReset(input bit power);
    @(negedge clk);
    cmdWren = 0; cmdWrdi = 0; cmdWrsr = 0; busy = 0;
    if (power) porN = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    mWen = 1'b0; mPrevBusy = 1'b0;
    if (power) mBp = 2'b00;
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #4;
    while (expQ.size() > 0) begin
      expect_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      compared++;
      if (statusByte !== e.st || arrayWriteOk !== e.arr || statusWriteOk !== e.sto) begin
        mismatched++;
        $display("FAIL %s: status=%02h arr=%b st=%b expected status=%02h arr=%b st=%b",
                 t, statusByte, arrayWriteOk, statusWriteOk, e.st, e.arr, e.sto);
      end
    end
  end

  initial begin
    doReset(1'b1);
    step(0,0,0,8'h00,1,0,9'h000, "R1 power-on state");
    step(1,0,0,8'h00,1,0,9'h000, "R2 set-enable");
    step(0,0,1,8'hF4,1,0,9'h17F, "R4 status write code 01, other bits ignored");
    step(0,0,0,8'h00,1,1,9'h000, "R3 busy byte 0x01");
    step(0,1,0,8'h00,0,1,9'h000, "R8 clear-enable while busy ignored");
    step(0,0,0,8'h00,1,0,9'h17F, "R7 cycle end clears latch");
    step(1,0,0,8'h00,1,0,9'h17F, "R5 code 01 allows 0x17F");
    step(0,0,0,8'h00,1,0,9'h180, "R5 code 01 blocks 0x180");
    step(0,0,1,8'h0B,1,0,9'h0FF, "R4 status write code 10");
    step(1,0,1,8'h0C,1,1,9'h0FF, "R8 commands while busy ignored");
    step(1,0,0,8'h00,1,0,9'h0FF, "R7 set-enable wins at cycle end");
    step(0,0,0,8'h00,1,0,9'h100, "R5 code 10 blocks 0x100");
    step(0,0,0,8'h00,0,0,9'h000, "R6 write-protect low blocks");
    step(0,0,1,8'h0C,0,0,9'h000, "R4 status write refused with protect low");
    step(1,1,0,8'h00,1,0,9'h000, "R2 both pulses leave latch clear");
    step(0,0,1,8'h0C,1,0,9'h000, "R6 status write refused with latch clear");
    step(1,0,0,8'h00,1,0,9'h000, "R2 set again");
    step(0,0,1,8'h0C,1,0,9'h000, "R5 code 11 blocks 0x000");
    step(0,0,0,8'h00,1,1,9'h000, "R3 busy after write");
    step(0,0,0,8'h00,1,0,9'h000, "R7 end of cycle");
    step(1,0,0,8'h00,1,0,9'h000, "R9 latch set before warm reset");
    doReset(1'b0);
    step(0,0,0,8'h00,1,0,9'h000, "R9 warm reset keeps code 11");
    doReset(1'b1);
    step(1,0,0,8'h00,1,0,9'h1FF, "R9 power-on clears code, 0x1FF open");
    step(0,0,0,8'h00,1,0,9'h000, "R5 code 00 allows 0x000");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule